// File: doc/BRIEF.md
# Width-Limited In-Order Retire Controller

This block sits at the tail of an out-of-order pipeline and decides, each cycle, how many of the oldest reorder-buffer entries of a thread leave the buffer. The buffer presents its W oldest entries side by side, slot 0 being the oldest. For each slot the block reads a small attribute byte and a sequence number. It scans the slots from oldest to youngest and returns three strobe masks: entries that commit, squashed entries that are dropped, and entries whose can-commit flag must be cleared because a request was sent back up the pipeline.

The side information for earlier stages is registered and appears one cycle after the scan. It covers the non-speculative sequence number, an uncached-load request, a trap request, the sequence number of the youngest committed entry, the architectural PC, a store-retired flag, a buffer-empty indication, a free-entry broadcast, a counter of cycles that used the full retire width and an error flag for heads that cannot be handled.

A two-state machine controls the scan. In state ST_RUN the scan is enabled. The transition RUN_TO_TRAP fires when a faulting head is accepted. In state ST_TRAP nothing retires, and the transition TRAP_TO_RUN fires on `trap_ack`, which also loads `resume_pc` into the PC.

Top module: `retire_ctrl`

## Requirements
- R1: Each slot attribute byte is encoded as bit 7 valid, bit 6 ready, bit 5 squashed, bit 4 executed, bit 3 non-speculative/store-conditional/barrier, bit 2 load, bit 1 fault and bit 0 store. At most W entries leave per cycle. The scan stops at the first slot that is invalid, not ready, or unable to commit, so the removed slots always form a prefix starting at slot 0.
- R2: A valid squashed slot is dropped whether or not it is ready. It is reported in `ret_drop`, never in `ret_commit`, and does not count as a retirement for the first-retirement rule.
- R3: An unexecuted non-speculative slot is accepted only when no entry has committed earlier in the cycle and `st_pend` is low. When accepted, its `ret_clr` bit is set and, one cycle later, `ns_valid` pulses with `ns_seq` equal to its sequence number. In every case nothing younger is removed.
- R4: An unexecuted load slot follows the same gating as R3. When accepted, its `ret_clr` bit is set and `unc_req` pulses one cycle later.
- R5: An executed faulting slot is accepted only as the first retirement of the cycle with `st_pend` low. It is never removed. When accepted, `trap_req` pulses and `trap_wait` rises one cycle later. While `trap_wait` is high no slot is removed. `trap_ack` lowers `trap_wait` and loads `resume_pc` into `arch_pc`.
- R6: After each cycle with commits, `done_seq` holds the sequence number of the youngest committed slot, and `arch_pc` has advanced by INSN_BYTES for each committed slot.
- R7: `st_retired` is high in the cycle after a cycle in which a store slot committed.
- R8: `buf_empty` is set one cycle after a cycle in which `buf_empty_next` is high, `st_pend` is low and no store committed. Otherwise it is low.
- R9: When any slot is removed or `alloc_now` is nonzero, `free_valid` pulses one cycle later with `free_cnt` = `free_now` + removed − `alloc_now`. Otherwise `free_valid` is low.
- R10: `bw_full_cnt` increments one cycle after each cycle in which exactly W slots committed.
- R11: An unexecuted, ready, non-squashed slot that is neither non-speculative nor a load sets `bad_head` one cycle later. It is not removed.
- R12: After reset, `arch_pc` = RESET_PC, `buf_empty` = 1, `trap_wait` = 0, and all counters, pulses and sequence outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_attr | input | W*8 | Attribute bytes of the W oldest entries, slot 0 in the low byte |
| hd_seq | input | W*SEQ_W | Sequence numbers of those entries |
| st_pend | input | 1 | Stores are still waiting to write back |
| buf_empty_next | input | 1 | Buffer is empty once this cycle's removals apply |
| free_now | input | FREE_W | Current free-entry count of the buffer |
| alloc_now | input | FREE_W | Entries allocated into the buffer this cycle |
| trap_ack | input | 1 | Trap handling done; leave trap state |
| resume_pc | input | PC_W | PC loaded on trap_ack |
| ret_commit | output | W | Slots committed this cycle |
| ret_drop | output | W | Squashed slots dropped this cycle |
| ret_clr | output | W | Slots whose can-commit flag is cleared |
| ns_valid | output | 1 | Non-speculative request pulse |
| ns_seq | output | SEQ_W | Sequence number of that request |
| unc_req | output | 1 | Uncached-load request pulse |
| trap_req | output | 1 | Trap request pulse |
| trap_wait | output | 1 | In trap state |
| done_seq | output | SEQ_W | Youngest committed sequence number |
| arch_pc | output | PC_W | Architectural PC |
| st_retired | output | 1 | A store committed last cycle |
| buf_empty | output | 1 | Empty indication for earlier stages |
| free_valid | output | 1 | Free-count broadcast strobe |
| free_cnt | output | FREE_W | Broadcast free-entry count |
| bw_full_cnt | output | CNT_W | Cycles that committed W slots |
| bad_head | output | 1 | Unhandled unexecuted head seen |

## Verification
A retiring store and the empty indication can fall in the same cycle. So can a committing entry and a gated non-speculative, load or faulting entry later in the same window. The bench provokes the first case by retiring a store while `buf_empty_next` is high and `st_pend` is low, and it judges that `buf_empty` stays low that cycle and rises only on the following clean cycle. For the second case it places an executed entry ahead of a non-speculative or faulting one. It checks that only the older entry commits and that no request or trap appears.

// File: rtl/retire_pkg.sv
`timescale 1ns/1ps
package retire_pkg;

    typedef struct packed {
        logic valid;
        logic ready;
        logic squashed;
        logic executed;
        logic nonspec;
        logic load;
        logic fault;
        logic store;
    } head_attr_t;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_TRAP = 1'b1
    } rc_state_t;

endpackage

// File: rtl/retire_scan.sv
`timescale 1ns/1ps
module retire_scan #(
    parameter int W     = 4,
    parameter int SEQ_W = 16
) (
    input  logic             enable,
    input  logic [W*8-1:0]   hd_attr,
    input  logic [W*SEQ_W-1:0] hd_seq,
    input  logic             st_pend,
    output logic [W-1:0]     commit_mask,
    output logic [W-1:0]     drop_mask,
    output logic [W-1:0]     clr_mask,
    output logic             ns_hit,
    output logic [SEQ_W-1:0] ns_seq_c,
    output logic             unc_hit,
    output logic             fault_hit,
    output logic             err_hit,
    output logic             store_hit,
    output logic             any_commit,
    output logic [SEQ_W-1:0] last_seq
);
    import retire_pkg::*;

    logic       halt;
    head_attr_t a;

    always_comb begin
        halt        = 1'b0;
        a           = '0;
        commit_mask = '0;
        drop_mask   = '0;
        clr_mask    = '0;
        ns_hit      = 1'b0;
        ns_seq_c    = '0;
        unc_hit     = 1'b0;
        fault_hit   = 1'b0;
        err_hit     = 1'b0;
        store_hit   = 1'b0;
        any_commit  = 1'b0;
        last_seq    = '0;
        for (int i = 0; i < W; i++) begin
            a = head_attr_t'(hd_attr[i*8 +: 8]);
            if (enable && !halt) begin
                if (!a.valid) begin
                    halt = 1'b1;
                end else if (a.squashed) begin
                    drop_mask[i] = 1'b1;
                end else if (!a.ready) begin
                    halt = 1'b1;
                end else if (!a.executed) begin
                    halt = 1'b1;
                    if (a.nonspec || a.load) begin
                        if (!any_commit && !st_pend) begin
                            clr_mask[i] = 1'b1;
                            if (a.nonspec) begin
                                ns_hit   = 1'b1;
                                ns_seq_c = hd_seq[i*SEQ_W +: SEQ_W];
                            end else begin
                                unc_hit = 1'b1;
                            end
                        end
                    end else begin
                        err_hit = 1'b1;
                    end
                end else if (a.fault) begin
                    halt = 1'b1;
                    if (!any_commit && !st_pend) begin
                        fault_hit = 1'b1;
                    end
                end else begin
                    commit_mask[i] = 1'b1;
                    any_commit     = 1'b1;
                    last_seq       = hd_seq[i*SEQ_W +: SEQ_W];
                    if (a.store) begin
                        store_hit = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/retire_fsm.sv
`timescale 1ns/1ps
module retire_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_hit,
    input  logic trap_ack,
    output logic scan_en,
    output logic trap_wait,
    output logic leave_trap
);
    import retire_pkg::*;

    rc_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d       = st_q;
        scan_en    = 1'b0;
        trap_wait  = 1'b0;
        leave_trap = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                scan_en = 1'b1;
                if (fault_hit) begin
                    st_d = ST_TRAP;
                end
            end
            ST_TRAP: begin
                trap_wait = 1'b1;
                if (trap_ack) begin
                    leave_trap = 1'b1;
                    st_d       = ST_RUN;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    // R5
    trap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_hit && st_q == ST_RUN) |=> (st_q == ST_TRAP));

endmodule

// File: rtl/retire_status.sv
`timescale 1ns/1ps
module retire_status #(
    parameter int              W          = 4,
    parameter int              SEQ_W      = 16,
    parameter int              PC_W       = 32,
    parameter int              FREE_W     = 6,
    parameter int              CNT_W      = 16,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      commit_mask,
    input  logic [W-1:0]      drop_mask,
    input  logic              ns_hit,
    input  logic [SEQ_W-1:0]  ns_seq_c,
    input  logic              unc_hit,
    input  logic              fault_hit,
    input  logic              err_hit,
    input  logic              store_hit,
    input  logic              any_commit,
    input  logic [SEQ_W-1:0]  last_seq,
    input  logic              st_pend,
    input  logic              buf_empty_next,
    input  logic [FREE_W-1:0] free_now,
    input  logic [FREE_W-1:0] alloc_now,
    input  logic              leave_trap,
    input  logic [PC_W-1:0]   resume_pc,
    output logic              ns_valid,
    output logic [SEQ_W-1:0]  ns_seq,
    output logic              unc_req,
    output logic              trap_req,
    output logic [SEQ_W-1:0]  done_seq,
    output logic [PC_W-1:0]   arch_pc,
    output logic              st_retired,
    output logic              buf_empty,
    output logic              free_valid,
    output logic [FREE_W-1:0] free_cnt,
    output logic [CNT_W-1:0]  bw_full_cnt,
    output logic              bad_head
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] n_commit;
    logic [CW-1:0] n_removed;
    logic          changed;

    assign n_commit  = CW'($countones(commit_mask));
    assign n_removed = CW'($countones(commit_mask | drop_mask));
    assign changed   = (n_removed != '0) || (alloc_now != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ns_valid    <= 1'b0;
            ns_seq      <= '0;
            unc_req     <= 1'b0;
            trap_req    <= 1'b0;
            done_seq    <= '0;
            arch_pc     <= RESET_PC;
            st_retired  <= 1'b0;
            buf_empty   <= 1'b1;
            free_valid  <= 1'b0;
            free_cnt    <= '0;
            bw_full_cnt <= '0;
            bad_head    <= 1'b0;
        end else begin
            ns_valid   <= ns_hit;
            unc_req    <= unc_hit;
            trap_req   <= fault_hit;
            bad_head   <= err_hit;
            st_retired <= store_hit;
            buf_empty  <= buf_empty_next && !st_pend && !store_hit;
            free_valid <= changed;
            if (ns_hit) begin
                ns_seq <= ns_seq_c;
            end
            if (any_commit) begin
                done_seq <= last_seq;
            end
            if (changed) begin
                free_cnt <= free_now + FREE_W'(n_removed) - alloc_now;
            end
            if (leave_trap) begin
                arch_pc <= resume_pc;
            end else begin
                arch_pc <= arch_pc + PC_W'(n_commit) * PC_W'(INSN_BYTES);
            end
            if (n_commit == CW'(W)) begin
                bw_full_cnt <= bw_full_cnt + 1'b1;
            end
        end
    end

    // R8
    store_blocks_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_hit |=> !buf_empty);

    // R10
    bw_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (n_commit == CW'(W)) |=> (bw_full_cnt == $past(bw_full_cnt) + 1'b1));

    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!leave_trap && n_commit == '0) |=> $stable(arch_pc));

endmodule

// File: rtl/retire_ctrl.sv
`timescale 1ns/1ps
module retire_ctrl #(
    parameter int              W          = 4,
    parameter int              SEQ_W      = 16,
    parameter int              PC_W       = 32,
    parameter int              FREE_W     = 6,
    parameter int              CNT_W      = 16,
    parameter int              INSN_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = 32'h0000_1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [W*8-1:0]       hd_attr,
    input  logic [W*SEQ_W-1:0]   hd_seq,
    input  logic                 st_pend,
    input  logic                 buf_empty_next,
    input  logic [FREE_W-1:0]    free_now,
    input  logic [FREE_W-1:0]    alloc_now,
    input  logic                 trap_ack,
    input  logic [PC_W-1:0]      resume_pc,
    output logic [W-1:0]         ret_commit,
    output logic [W-1:0]         ret_drop,
    output logic [W-1:0]         ret_clr,
    output logic                 ns_valid,
    output logic [SEQ_W-1:0]     ns_seq,
    output logic                 unc_req,
    output logic                 trap_req,
    output logic                 trap_wait,
    output logic [SEQ_W-1:0]     done_seq,
    output logic [PC_W-1:0]      arch_pc,
    output logic                 st_retired,
    output logic                 buf_empty,
    output logic                 free_valid,
    output logic [FREE_W-1:0]    free_cnt,
    output logic [CNT_W-1:0]     bw_full_cnt,
    output logic                 bad_head
);
    logic             scan_en;
    logic             leave_trap;
    logic             ns_hit, unc_hit, fault_hit, err_hit, store_hit, any_commit;
    logic [SEQ_W-1:0] ns_seq_c, last_seq;
    logic [W-1:0]     removed;

    retire_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_hit  (fault_hit),
        .trap_ack   (trap_ack),
        .scan_en    (scan_en),
        .trap_wait  (trap_wait),
        .leave_trap (leave_trap)
    );

    retire_scan #(.W(W), .SEQ_W(SEQ_W)) u_scan (
        .enable      (scan_en),
        .hd_attr     (hd_attr),
        .hd_seq      (hd_seq),
        .st_pend     (st_pend),
        .commit_mask (ret_commit),
        .drop_mask   (ret_drop),
        .clr_mask    (ret_clr),
        .ns_hit      (ns_hit),
        .ns_seq_c    (ns_seq_c),
        .unc_hit     (unc_hit),
        .fault_hit   (fault_hit),
        .err_hit     (err_hit),
        .store_hit   (store_hit),
        .any_commit  (any_commit),
        .last_seq    (last_seq)
    );

    retire_status #(
        .W(W), .SEQ_W(SEQ_W), .PC_W(PC_W), .FREE_W(FREE_W),
        .CNT_W(CNT_W), .INSN_BYTES(INSN_BYTES), .RESET_PC(RESET_PC)
    ) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .commit_mask    (ret_commit),
        .drop_mask      (ret_drop),
        .ns_hit         (ns_hit),
        .ns_seq_c       (ns_seq_c),
        .unc_hit        (unc_hit),
        .fault_hit      (fault_hit),
        .err_hit        (err_hit),
        .store_hit      (store_hit),
        .any_commit     (any_commit),
        .last_seq       (last_seq),
        .st_pend        (st_pend),
        .buf_empty_next (buf_empty_next),
        .free_now       (free_now),
        .alloc_now      (alloc_now),
        .leave_trap     (leave_trap),
        .resume_pc      (resume_pc),
        .ns_valid       (ns_valid),
        .ns_seq         (ns_seq),
        .unc_req        (unc_req),
        .trap_req       (trap_req),
        .done_seq       (done_seq),
        .arch_pc        (arch_pc),
        .st_retired     (st_retired),
        .buf_empty      (buf_empty),
        .free_valid     (free_valid),
        .free_cnt       (free_cnt),
        .bw_full_cnt    (bw_full_cnt),
        .bad_head       (bad_head)
    );

    assign removed = ret_commit | ret_drop;

    // R1
    prefix_removal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((removed + 1'b1) & removed) == '0);

    // R3
    ns_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_clr != '0) |-> (ret_commit == '0));

    // R5
    trap_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_wait);

    // R5
    trap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_wait |-> (removed == '0 && ret_clr == '0));

endmodule

// File: tb/sim_retire_ctrl.sv
`timescale 1ns/1ps
module sim_retire_ctrl;
    localparam int W = 4;
    localparam int SEQ_W = 16;
    localparam int PC_W = 32;
    localparam int FREE_W = 6;
    localparam int CNT_W = 16;
    localparam logic [PC_W-1:0] RPC = 32'h0000_1000;

    localparam logic [7:0] A_E  = 8'hD0;
    localparam logic [7:0] A_S  = 8'hE0;
    localparam logic [7:0] A_ST = 8'hD1;
    localparam logic [7:0] A_F  = 8'hD2;
    localparam logic [7:0] A_N  = 8'hC8;
    localparam logic [7:0] A_L  = 8'hC4;
    localparam logic [7:0] A_X  = 8'hC0;
    localparam logic [7:0] A_NR = 8'h80;
    localparam logic [7:0] A_I  = 8'h00;

    // {attrs s3..s0, st_pend, commit, drop, clr, ns, unc, store}
    localparam int NV = 10;
    localparam logic [47:0] VECS [NV] = '{
        {A_E, A_E, A_E, A_E,  1'b0, 4'b1111, 4'b0000, 4'b0000, 3'b000},
        {A_E, A_E, A_NR, A_E, 1'b0, 4'b0001, 4'b0000, 4'b0000, 3'b000},
        {A_E, A_S, A_E, A_S,  1'b0, 4'b1010, 4'b0101, 4'b0000, 3'b000},
        {A_E, A_E, A_E, A_N,  1'b0, 4'b0000, 4'b0000, 4'b0001, 3'b100},
        {A_E, A_E, A_N, A_E,  1'b0, 4'b0001, 4'b0000, 4'b0000, 3'b000},
        {A_I, A_I, A_I, A_N,  1'b1, 4'b0000, 4'b0000, 4'b0000, 3'b000},
        {A_E, A_E, A_N, A_S,  1'b0, 4'b0000, 4'b0001, 4'b0010, 3'b100},
        {A_E, A_E, A_E, A_L,  1'b0, 4'b0000, 4'b0000, 4'b0001, 3'b010},
        {A_E, A_E, A_E, A_I,  1'b0, 4'b0000, 4'b0000, 4'b0000, 3'b000},
        {A_E, A_E, A_ST, A_E, 1'b0, 4'b1111, 4'b0000, 4'b0000, 3'b001}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W*8-1:0] hd_attr = '0;
    logic [W*SEQ_W-1:0] hd_seq;
    logic st_pend = 1'b0;
    logic buf_empty_next = 1'b0;
    logic [FREE_W-1:0] free_now = '0;
    logic [FREE_W-1:0] alloc_now = '0;
    logic trap_ack = 1'b0;
    logic [PC_W-1:0] resume_pc = 32'h0000_2000;

    logic [W-1:0] ret_commit, ret_drop, ret_clr;
    logic ns_valid, unc_req, trap_req, trap_wait, st_retired, buf_empty, free_valid, bad_head;
    logic [SEQ_W-1:0] ns_seq, done_seq;
    logic [PC_W-1:0] arch_pc;
    logic [FREE_W-1:0] free_cnt;
    logic [CNT_W-1:0] bw_full_cnt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    assign hd_seq = {16'd103, 16'd102, 16'd101, 16'd100};

    retire_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hd_attr(hd_attr), .hd_seq(hd_seq),
        .st_pend(st_pend), .buf_empty_next(buf_empty_next),
        .free_now(free_now), .alloc_now(alloc_now),
        .trap_ack(trap_ack), .resume_pc(resume_pc),
        .ret_commit(ret_commit), .ret_drop(ret_drop), .ret_clr(ret_clr),
        .ns_valid(ns_valid), .ns_seq(ns_seq), .unc_req(unc_req),
        .trap_req(trap_req), .trap_wait(trap_wait), .done_seq(done_seq),
        .arch_pc(arch_pc), .st_retired(st_retired), .buf_empty(buf_empty),
        .free_valid(free_valid), .free_cnt(free_cnt),
        .bw_full_cnt(bw_full_cnt), .bad_head(bad_head)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] at, input logic sp);
        @(negedge clk);
        hd_attr = at;
        st_pend = sp;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [PC_W-1:0] pc0;
        logic [CNT_W-1:0] bw0;
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check("R12 pc", arch_pc, RPC);
        check("R12 empty", buf_empty, 1);
        check("R12 trap", trap_wait, 0);
        check("R12 bw", bw_full_cnt, 0);
        check("R12 seq", done_seq, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [47:0] e;
            int hi;
            int ci;
            e = VECS[v];
            drive(e[47:16], e[15]);
            #1;
            check("R1 commit", ret_commit, e[14:11]);
            check("R2 drop", ret_drop, e[10:7]);
            check("R3 clr", ret_clr, e[6:3]);
            pc0 = arch_pc;
            hi = -1;
            ci = 0;
            for (int k = 0; k < W; k++) begin
                if (e[11+k]) hi = k;
                if (e[3+k]) ci = k;
            end
            after_edge();
            check("R6 pc", arch_pc, pc0 + 32'($countones(e[14:11])) * 4);
            if (hi >= 0) check("R6 done", done_seq, 100 + hi);
            check("R3 ns", ns_valid, e[2]);
            if (e[2]) check("R3 nsseq", ns_seq, 100 + ci);
            check("R4 unc", unc_req, e[1]);
            check("R7 store", st_retired, e[0]);
        end

        // R5 fault behind a commit is not the first retirement
        drive({A_I, A_I, A_F, A_E}, 1'b0);
        #1;
        check("R5 commit before fault", ret_commit, 4'b0001);
        after_edge();
        check("R5 gated by commit", trap_req, 0);
        // R5 fault with stores pending
        drive({A_I, A_I, A_I, A_F}, 1'b1);
        after_edge();
        check("R5 gated by stores", trap_req, 0);
        drive({A_I, A_I, A_I, A_F}, 1'b0);
        #1;
        check("R5 fault not removed", ret_commit | ret_drop, 0);
        after_edge();
        check("R5 trap req", trap_req, 1);
        check("R5 trap wait", trap_wait, 1);
        drive({A_E, A_E, A_E, A_E}, 1'b0);
        #1;
        check("R5 no retire in trap", ret_commit, 0);
        after_edge();
        check("R5 trap pulse", trap_req, 0);
        @(negedge clk);
        hd_attr = '0;
        trap_ack = 1'b1;
        after_edge();
        check("R5 trap leave", trap_wait, 0);
        check("R5 resume pc", arch_pc, 32'h0000_2000);
        @(negedge clk);
        trap_ack = 1'b0;

        // R11 unknown unexecuted head
        drive({A_E, A_E, A_E, A_X}, 1'b0);
        #1;
        check("R11 no retire", ret_commit, 0);
        after_edge();
        check("R11 flag", bad_head, 1);

        // R8 store retiring while buffer drains
        drive({A_I, A_I, A_I, A_ST}, 1'b0);
        buf_empty_next = 1'b1;
        after_edge();
        check("R7 store flag", st_retired, 1);
        check("R8 empty held by store", buf_empty, 0);
        drive('0, 1'b0);
        after_edge();
        check("R8 empty", buf_empty, 1);
        check("R7 store clear", st_retired, 0);
        drive('0, 1'b1);
        after_edge();
        check("R8 stores pending", buf_empty, 0);
        buf_empty_next = 1'b0;

        // R9 free-entry broadcast
        drive({A_I, A_E, A_E, A_E}, 1'b0);
        free_now = 6'd10;
        alloc_now = 6'd2;
        after_edge();
        check("R9 valid", free_valid, 1);
        check("R9 count", free_cnt, 11);
        drive('0, 1'b0);
        alloc_now = '0;
        after_edge();
        check("R9 idle", free_valid, 0);

        // R10 bandwidth counter
        bw0 = bw_full_cnt;
        drive({A_E, A_E, A_E, A_E}, 1'b0);
        after_edge();
        check("R10 full", bw_full_cnt, bw0 + 1);
        drive({A_I, A_E, A_E, A_E}, 1'b0);
        after_edge();
        check("R10 partial", bw_full_cnt, bw0 + 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule